// File: doc/BRIEF.md
# Firmware Region Write-Control Register

This block is one byte-wide control register. It decides whether the boot-firmware region of a flash device may be written. Software reaches it through a simple configuration port: a byte address, write data, a write strobe and combinational read data. The register answers only at one parameterised offset.

Two bits are set-once locks, and both change how the write-enable bit behaves:
- **Interrupt lock.** Once it is set, every write that puts a 1 into the write-enable bit raises a one-cycle management-interrupt request. A handler can then decide whether to undo the write.
- **Management-mode protect.** Once it is set, the firmware region is writable only while the current access is flagged as coming from system management mode.

The combined permission is presented on a single output. The flash interface consumes it. The register also carries a 2-bit read-configuration field and a read-only top-swap status bit that comes from a pin.

Top module: `bios_wctl`

## Requirements
- R1: After reset the write enable (bit 0), the interrupt lock (bit 1) and the management-mode protect (bit 5) are 0. The read-configuration field (bits 3:2) holds RCFG_RST (default 2). With the top-swap pin low, a read at the register offset returns 0x08. `fw_writable_o` and `smi_req_o` are 0.
- R2: Only the offset REG_ADDR (default 0xDC) is decoded. A write to any other address changes no register bit. A read at any other address returns 0x00.
- R3: Bit 0 (write enable) is freely read/write. `fw_writable_o` is 0 whenever bit 0 is 0.
- R4: Bit 1 (interrupt lock) is set by writing 1. Writes of 0 leave it set until reset.
- R5: `smi_req_o` is high for exactly the one cycle after a register write whose data bit 0 is 1, provided the interrupt lock was already 1 before that write. It stays 0 for every other write.
- R6: Bit 5 (management-mode protect) is set by writing 1. Writes of 0 leave it set until reset.
- R7: `fw_writable_o` = bit0 AND (NOT bit5 OR `smm_i`), and it follows `smm_i` in the same cycle.
- R8: Bits 3:2 (read configuration) are read/write.
- R9: Bit 4 reads the `top_swap_i` pin, and bus writes to it are ignored. Bits 7:6 always read 0.
- R10: With both locks clear, writing 0x09 reads back 0x09 and makes `fw_writable_o` 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_addr_i | input | ADDR_W | Configuration byte address |
| cfg_wdata_i | input | 8 | Write data |
| cfg_we_i | input | 1 | Write strobe, one write per cycle high |
| cfg_rdata_o | output | 8 | Read data for the addressed offset |
| smm_i | input | 1 | Current access is in system management mode |
| top_swap_i | input | 1 | Top-swap status shown in bit 4 |
| fw_writable_o | output | 1 | Firmware region may be written |
| smi_req_o | output | 1 | One-cycle management-interrupt request |

## Verification
A lock bit that wrongly clears shows up in the read data on the first read after the offending write. It also shows up on `fw_writable_o` in the same cycle that `smm_i` drops.

A faulty interrupt path shows up one cycle after the triggering write, as a missing pulse, an extra pulse or a pulse that lasts too long. The bench samples that cycle and the one after it.

A wrong decode shows up as a changed read value at the real offset after writes aimed at a neighbouring address.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int REG_W    = 8;
  localparam int RCFG_W   = 2;
  localparam int BIT_WEN  = 0;
  localparam int BIT_LOCK = 1;
  localparam int RCFG_LSB = 2;
  localparam int BIT_TSS  = 4;
  localparam int BIT_SMMP = 5;
  localparam int N_STICKY = 2;
  // sticky index map
  localparam int STK_LOCK = 0;
  localparam int STK_SMMP = 1;

  typedef struct packed {
    logic [1:0]        rsvd;
    logic              smm_prot;
    logic              tss;
    logic [RCFG_W-1:0] rcfg;
    logic              lock;
    logic              wen;
  } bwc_reg_t;
endpackage

// File: rtl/bwc_cfg_decode.sv
module bwc_cfg_decode #(
  parameter int              ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'hDC
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  output logic              hit_o,
  output logic              wr_o
);
  always_comb begin
    hit_o = (addr_i == REG_ADDR);
    wr_o  = hit_o & we_i;
  end
endmodule

// File: rtl/bwc_sticky.sv
module bwc_sticky #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [N-1:0] set_i,
  output logic [N-1:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 q_o[g] <= 1'b0;
      else if (wr_i && set_i[g])   q_o[g] <= 1'b1;
    end

    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(q_o[g]) |-> q_o[g]); // R4
  end
endmodule

// File: rtl/bwc_smi_gen.sv
module bwc_smi_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic lock_i,
  input  logic wen_data_i,
  output logic smi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) smi_o <= 1'b0;
    else         smi_o <= wr_i & lock_i & wen_data_i;
  end

  AST_SMI_NEEDS_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> $past(lock_i)); // R5
  AST_SMI_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_o |-> $past(wr_i)); // R5
endmodule

// File: rtl/bios_wctl.sv
module bios_wctl
  import bwc_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'hDC,
  parameter logic [RCFG_W-1:0] RCFG_RST = 2'd2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  input  logic              cfg_we_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  input  logic              smm_i,
  input  logic              top_swap_i,
  output logic              fw_writable_o,
  output logic              smi_req_o
);
  logic                hit, wr;
  logic                wen_q;
  logic [RCFG_W-1:0]   rcfg_q;
  logic [N_STICKY-1:0] stk_set, stk_q;
  bwc_reg_t            view;

  bwc_cfg_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_dec (
    .addr_i(cfg_addr_i), .we_i(cfg_we_i), .hit_o(hit), .wr_o(wr)
  );

  always_comb begin
    stk_set           = '0;
    stk_set[STK_LOCK] = cfg_wdata_i[BIT_LOCK];
    stk_set[STK_SMMP] = cfg_wdata_i[BIT_SMMP];
  end

  bwc_sticky #(.N(N_STICKY)) u_stk (
    .clk_i, .rst_ni, .wr_i(wr), .set_i(stk_set), .q_o(stk_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q  <= 1'b0;
      rcfg_q <= RCFG_RST;
    end else if (wr) begin
      wen_q  <= cfg_wdata_i[BIT_WEN];
      rcfg_q <= cfg_wdata_i[RCFG_LSB +: RCFG_W];
    end
  end

  bwc_smi_gen u_smi (
    .clk_i, .rst_ni, .wr_i(wr), .lock_i(stk_q[STK_LOCK]),
    .wen_data_i(cfg_wdata_i[BIT_WEN]), .smi_o(smi_req_o)
  );

  always_comb begin
    view          = '0;
    view.wen      = wen_q;
    view.lock     = stk_q[STK_LOCK];
    view.rcfg     = rcfg_q;
    view.tss      = top_swap_i;
    view.smm_prot = stk_q[STK_SMMP];
    cfg_rdata_o   = hit ? view : '0;
    fw_writable_o = wen_q & (~stk_q[STK_SMMP] | smm_i);
  end

  AST_WR_NEEDS_SMM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fw_writable_o && stk_q[STK_SMMP]) |-> smm_i); // R7
  AST_WR_NEEDS_WEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fw_writable_o |-> cfg_rdata_o[BIT_WEN] || !hit); // R3
  AST_OFFADDR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !hit) |=> ($stable(wen_q) && $stable(rcfg_q) && $stable(stk_q))); // R2
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_rdata_o[7:6] == 2'b00); // R9
endmodule

// File: tb/tb_bios_wctl.sv
`timescale 1ns/1ps
module tb_bios_wctl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] cfg_addr_i = 8'h00;
  logic [7:0] cfg_wdata_i = 8'h00;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_rdata_o;
  logic       smm_i = 1'b0;
  logic       top_swap_i = 1'b0;
  logic       fw_writable_o;
  logic       smi_req_o;

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;
  logic smi_seen;

  always #4 clk_i = ~clk_i;

  bios_wctl dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; cfg_we_i = 1'b0; smm_i = 1'b0; top_swap_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  // write at negedge, strobe for one edge; smi_seen is the cycle after the write
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    cfg_addr_i = a; cfg_wdata_i = d; cfg_we_i = 1'b1;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    smi_seen = smi_req_o;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    cfg_addr_i = a; #1; d = cfg_rdata_o;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    do_reset();
    rd(8'hDC, v);
    chk("R1 reset value", v, 8'h08);
    chk("R1 writable", {7'b0, fw_writable_o}, 8'h00);
    chk("R1 smi", {7'b0, smi_req_o}, 8'h00);
  endtask

  task automatic t_unlock_write();
    logic [7:0] v;
    wr(8'hDC, 8'h09);
    rd(8'hDC, v);
    chk("R10 readback", v, 8'h09);
    chk("R10 writable", {7'b0, fw_writable_o}, 8'h01);
    chk("R5 no smi without lock", {7'b0, smi_seen}, 8'h00);
  endtask

  task automatic t_decode();
    logic [7:0] v;
    wr(8'hDD, 8'hFF);
    rd(8'hDD, v);
    chk("R2 offaddr read", v, 8'h00);
    rd(8'hDC, v);
    chk("R2 offaddr write ignored", v, 8'h09);
  endtask

  task automatic t_fields();
    logic [7:0] v;
    wr(8'hDC, 8'h08);
    rd(8'hDC, v);
    chk("R3 wen cleared", v, 8'h08);
    chk("R3 writable low", {7'b0, fw_writable_o}, 8'h00);
    wr(8'hDC, 8'h0C);
    rd(8'hDC, v);
    chk("R8 rcfg=3", v, 8'h0C);
    top_swap_i = 1'b1;
    rd(8'hDC, v);
    chk("R9 tss pin", v, 8'h1C);
    wr(8'hDC, 8'hD0);
    rd(8'hDC, v);
    chk("R9 bits 7:6,4 not writable", v, 8'h10);
    top_swap_i = 1'b0;
    rd(8'hDC, v);
    chk("R9 tss follows pin", v, 8'h00);
  endtask

  task automatic t_lock_smi();
    logic [7:0] v;
    do_reset();
    wr(8'hDC, 8'h02);
    rd(8'hDC, v);
    chk("R4 lock set", v, 8'h02);
    chk("R5 no smi wen=0", {7'b0, smi_seen}, 8'h00);
    wr(8'hDC, 8'h00);
    rd(8'hDC, v);
    chk("R4 lock sticky", v, 8'h02);
    wr(8'hDC, 8'h01);
    chk("R5 smi pulse", {7'b0, smi_seen}, 8'h01);
    @(negedge clk_i);
    chk("R5 smi one cycle", {7'b0, smi_req_o}, 8'h00);
    rd(8'hDC, v);
    chk("R4 lock kept, wen set", v, 8'h03);
    wr(8'hDD, 8'h01);
    chk("R5 no smi offaddr", {7'b0, smi_seen}, 8'h00);
  endtask

  task automatic t_smm_prot();
    logic [7:0] v;
    do_reset();
    wr(8'hDC, 8'h21);
    rd(8'hDC, v);
    chk("R6 prot set", v, 8'h21);
    chk("R7 blocked outside smm", {7'b0, fw_writable_o}, 8'h00);
    smm_i = 1'b1; #1;
    chk("R7 allowed in smm", {7'b0, fw_writable_o}, 8'h01);
    wr(8'hDC, 8'h01);
    rd(8'hDC, v);
    chk("R6 prot sticky", v, 8'h01 | 8'h20);
    wr(8'hDC, 8'h20);
    chk("R7 wen=0 in smm", {7'b0, fw_writable_o}, 8'h00);
    smm_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_unlock_write();
    t_decode();
    t_fields();
    t_lock_smi();
    t_smm_prot();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule